// File: doc/BRIEF.md
# Serial Receiver with Byte-Wide Register Port

This block receives asynchronous serial characters on a single input line. A host reaches it through a small byte-wide register port. That port has a chip select, an active-low address strobe that captures the address, active-low read and write strobes, and separate input and output data buses. At run time the host programs the character format: 5 to 8 data bits, no parity, odd, even or fixed ("stick") parity, and one or two stop bits. It also programs a 16-bit baud divisor.

The line is sampled through a two-flop synchronizer. Sampling runs at sixteen ticks per bit time, and the divisor sets the clocks per tick. Each finished character is stored right-aligned in a receive buffer. Data-ready, overrun, parity-error and framing-error flags are posted in a line status register. A level interrupt is raised while unread data waits and the interrupt is enabled. Reading the status register clears the error flags but not data-ready. Reading the buffer clears data-ready and drops the interrupt.

Top module: `serial_rx_port`

## Requirements
- R1: After reset, line status reads 0x60, line control reads 0x03, interrupt enable reads 0x00, the divisor reads 0x0001 and `irq` is low.
- R2: The address is captured on each clock where `as_n` is low. A read captures data into `dout` on the first clock of a `cs`-qualified `rd_n` low pulse, and a write takes effect on the first clock of a `wr_n` low pulse. The offsets are buffer 0, interrupt enable 1, line control 3 and line status 5. Interrupt enable keeps only bits 3:0, and its upper bits read 0. While line control bit 7 is 1, offsets 0 and 1 reach the divisor low and high bytes instead.
- R3: A tick occurs every `divisor` clocks, and a divisor of 0 acts as 1. A low level is confirmed as a start bit 8 ticks after it is seen. Data is taken least significant bit first, and each later bit is sampled 16 ticks after the one before.
- R4: Line control bits [1:0] set the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. The character is right-aligned in the buffer and its unused upper bits read 0.
- R5: Line control bit 3 enables a parity bit after the data. Bit 4 at 1 selects even parity and at 0 selects odd parity. A mismatch sets line status bit 2.
- R6: When line control bits 5 and 3 are both 1, the expected parity bit is the inverse of line control bit 4, whatever the data.
- R7: With line control bit 2 at 0 there is one stop bit. At 1 there are two, or 1.5 when the word length is 5. A low sample on any stop bit sets line status bit 3.
- R8: Line status holds data-ready in bit 0, overrun in bit 1, parity error in bit 2 and framing error in bit 3. Bits 5 and 6 read 1 and bits 4 and 7 read 0. A status read clears bits 1 to 3 and leaves bit 0 unchanged.
- R9: A buffer read clears data-ready. A character that completes while data-ready is still set sets overrun and replaces the buffer contents.
- R10: `irq` equals interrupt enable bit 0 AND data-ready. It stays high across status reads and is low one clock after the capturing edge of a buffer read.
- R11: Line control bit 6 (break request) is stored and read back, and it has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, qualifies the read and write strobes |
| as_n | input | 1 | Address strobe, active low; address is captured while low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, captured at the start of a read |
| sin | input | 1 | Serial input line, idle high |
| irq | output | 1 | Received-data interrupt, level |

## Verification
The bench reads status twice in a row. A design whose status read consumed data-ready would then show 0x60 and drop `irq` early. It checks right alignment with all-ones 5- and 6-bit characters, where a left-aligned or unmasked buffer would show stray upper bits. Stick parity is driven with both parity levels under both even-select settings, because a design that computes real parity in that mode passes only by chance. The bench also covers overrun, framing errors on the second and the half stop bit, a masked interrupt that appears once enabled, and a divisor above 1. An off-by-one tick count or a missing 1.5-stop rule would mis-sample or miss those frames.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_REARM
  } rx_state_e;

  localparam logic [2:0] OFS_BUF = 3'd0;
  localparam logic [2:0] OFS_IER = 3'd1;
  localparam logic [2:0] OFS_LCR = 3'd3;
  localparam logic [2:0] OFS_LSR = 3'd5;

  typedef struct packed {
    logic       dlab;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       two_stop;
    logic [1:0] wlen;
  } line_ctl_t;

endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == '0) cnt_d = (div == '0) ? '0 : div - 1'b1;
    else             cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      sin,
  input  line_ctl_t lcr,
  output logic      done,
  output logic [7:0] data,
  output logic      perr,
  output logic      ferr
);
  localparam int OS_W = $clog2(OS);
  localparam logic [OS_W-1:0] MID       = OS_W'(OS / 2 - 1);
  localparam logic [OS_W-1:0] LAST      = OS_W'(OS - 1);
  localparam logic [OS_W-1:0] HALF_LAST = OS_W'(OS * 3 / 4 - 1);

  rx_state_e       st_q, st_d;
  logic [OS_W-1:0] cnt_q, cnt_d;
  logic [2:0]      idx_q, idx_d;
  logic [7:0]      sh_q, sh_d;
  logic            pe_q, pe_d, fe_q, fe_d, done_q, done_d;
  logic [2:0]      last_idx;
  logic            exp_par;
  logic [OS_W-1:0] stop2_last;

  assign last_idx   = 3'd4 + 3'(lcr.wlen);
  assign stop2_last = (lcr.wlen == 2'b00) ? HALF_LAST : LAST;
  assign exp_par    = lcr.stick ? ~lcr.even : (lcr.even ? (^sh_q) : ~(^sh_q));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!sin) begin
        st_d  = ST_START;
        cnt_d = '0;
      end
      ST_START: if (tick) begin
        if (cnt_q == MID) begin
          cnt_d = '0;
          if (!sin) begin
            st_d  = ST_DATA;
            idx_d = '0;
            sh_d  = '0;
            pe_d  = 1'b0;
            fe_d  = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_DATA: if (tick) begin
        if (cnt_q == LAST) begin
          cnt_d       = '0;
          sh_d[idx_q] = sin;
          if (idx_q == last_idx) st_d = lcr.par_en ? ST_PAR : ST_STOP1;
          else                   idx_d = idx_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PAR: if (tick) begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          pe_d  = (sin != exp_par);
          st_d  = ST_STOP1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STOP1: if (tick) begin
        if (cnt_q == LAST) begin
          cnt_d = '0;
          fe_d  = ~sin;
          if (lcr.two_stop) st_d = ST_STOP2;
          else begin
            done_d = 1'b1;
            st_d   = sin ? ST_IDLE : ST_REARM;
          end
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_STOP2: if (tick) begin
        if (cnt_q == stop2_last) begin
          cnt_d  = '0;
          fe_d   = fe_q | ~sin;
          done_d = 1'b1;
          st_d   = sin ? ST_IDLE : ST_REARM;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_REARM: if (sin) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;
  assign data = sh_q;
  assign perr = pe_q;
  assign ferr = fe_q;
endmodule

// File: rtl/srx_regs.sv
module srx_regs
  import srx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             as_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic [2:0]       addr,
  input  logic [7:0]       din,
  input  logic             rx_done,
  input  logic [7:0]       rx_data,
  input  logic             rx_perr,
  input  logic             rx_ferr,
  output logic [7:0]       dout,
  output logic             irq,
  output line_ctl_t        lcr,
  output logic [DIV_W-1:0] div,
  output logic             rd_buf,
  output logic             rd_lsr,
  output logic             dr,
  output logic [2:0]       err,
  output logic [7:0]       rbr
);
  localparam int DIV_BYTES = DIV_W / 8;

  logic [2:0]       addr_q;
  logic             rdn_q, wrn_q;
  logic             rd_go, wr_go;
  logic [7:0]       rdata;
  logic [3:0]       ier_q, ier_d;
  line_ctl_t        lcr_q, lcr_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [7:0]       rbr_q, rbr_d, dout_q, dout_d;
  logic             dr_q, dr_d, oe_q, oe_d, pe_q, pe_d, fe_q, fe_d;
  logic [7:0]       lsr;
  logic             sel_lo, sel_hi;

  assign rd_go  = cs & ~rd_n & rdn_q;
  assign wr_go  = cs & ~wr_n & wrn_q;
  assign sel_lo = (addr_q == OFS_BUF);
  assign sel_hi = (addr_q == OFS_IER);
  assign rd_buf = rd_go & sel_lo & ~lcr_q.dlab;
  assign rd_lsr = rd_go & (addr_q == OFS_LSR);
  assign lsr    = {1'b0, 1'b1, 1'b1, 1'b0, fe_q, pe_q, oe_q, dr_q};

  always_comb begin
    rdata = 8'h00;
    if (sel_lo)                   rdata = lcr_q.dlab ? div_q[7:0] : rbr_q;
    else if (sel_hi)              rdata = lcr_q.dlab ? div_q[DIV_W-1 -: 8] : {4'h0, ier_q};
    else if (addr_q == OFS_LCR)   rdata = lcr_q;
    else if (addr_q == OFS_LSR)   rdata = lsr;
  end

  always_comb begin
    ier_d  = ier_q;
    lcr_d  = lcr_q;
    div_d  = div_q;
    rbr_d  = rx_done ? rx_data : rbr_q;
    dout_d = rd_go ? rdata : dout_q;
    dr_d   = (dr_q & ~rd_buf) | rx_done;
    oe_d   = (oe_q & ~rd_lsr) | (rx_done & dr_q & ~rd_buf);
    pe_d   = (pe_q & ~rd_lsr) | (rx_done & rx_perr);
    fe_d   = (fe_q & ~rd_lsr) | (rx_done & rx_ferr);
    if (wr_go) begin
      if (sel_lo) begin
        if (lcr_q.dlab) div_d[7:0] = din;
      end else if (sel_hi) begin
        if (lcr_q.dlab) div_d[DIV_W-1 -: 8] = din;
        else            ier_d = din[3:0];
      end else if (addr_q == OFS_LCR) begin
        lcr_d = din;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rdn_q  <= 1'b1;
      wrn_q  <= 1'b1;
      ier_q  <= '0;
      lcr_q  <= 8'h03;
      div_q  <= DIV_W'(1);
      rbr_q  <= '0;
      dout_q <= '0;
      dr_q   <= 1'b0;
      oe_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      if (!as_n) addr_q <= addr;
      rdn_q  <= rd_n | ~cs;
      wrn_q  <= wr_n | ~cs;
      ier_q  <= ier_d;
      lcr_q  <= lcr_d;
      div_q  <= div_d;
      rbr_q  <= rbr_d;
      dout_q <= dout_d;
      dr_q   <= dr_d;
      oe_q   <= oe_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
    end
  end

  assign dout = dout_q;
  assign irq  = ier_q[0] & dr_q;
  assign lcr  = lcr_q;
  assign div  = div_q;
  assign dr   = dr_q;
  assign err  = {fe_q, pe_q, oe_q};
  assign rbr  = rbr_q;
  if (DIV_BYTES < 2) begin : g_div_chk
    initial $display("divisor narrower than two bytes");
  end
endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port
  import srx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OS    = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       as_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] addr,
  input  logic [7:0] din,
  output logic [7:0] dout,
  input  logic       sin,
  output logic       irq
);
  logic             sin_m, sin_s;
  logic             tick;
  line_ctl_t        lcr;
  logic [DIV_W-1:0] div;
  logic             rx_done, rx_perr, rx_ferr;
  logic [7:0]       rx_data;
  logic             rd_buf, rd_lsr, dr;
  logic [2:0]       err;
  logic [7:0]       rbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_m <= 1'b1;
      sin_s <= 1'b1;
    end else begin
      sin_m <= sin;
      sin_s <= sin_m;
    end
  end

  srx_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
  );

  srx_frame #(.OS(OS)) i_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sin(sin_s), .lcr(lcr),
    .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  srx_regs #(.DIV_W(DIV_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .rx_done(rx_done), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .dout(dout), .irq(irq),
    .lcr(lcr), .div(div), .rd_buf(rd_buf), .rd_lsr(rd_lsr), .dr(dr),
    .err(err), .rbr(rbr)
  );
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       rd_buf,
  input logic       rd_lsr,
  input logic       done,
  input logic       dr,
  input logic [2:0] err,
  input logic [7:0] rbr,
  input logic [1:0] wlen
);
  // R10
  irq_drop_on_buf_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_buf && !done) |=> !irq);
  // R8
  lsr_read_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && dr) |=> dr);
  // R8
  lsr_read_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !done) |=> (err == 3'b000));
  // R9
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> dr);
  // R9
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dr && !rd_buf) |=> err[0]);
  // R4
  five_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wlen == 2'b00) |=> (rbr[7:5] == 3'b000));
endmodule

bind serial_rx_port srx_checker i_srx_checker (
  .clk(clk), .rst_n(rst_n), .irq(irq), .rd_buf(rd_buf), .rd_lsr(rd_lsr),
  .done(rx_done), .dr(dr), .err(err), .rbr(rbr), .wlen(lcr.wlen)
);

// File: tb/test_serial_rx_port.sv
module test_serial_rx_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, cs, as_n, rd_n, wr_n, sin;
  logic [2:0] addr;
  logic [7:0] din;
  logic [7:0] dout;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  int         div_cur = 1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_rx_port i_serial_rx_port (
    .clk(clk), .rst_n(rst_n), .cs(cs), .as_n(as_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .sin(sin), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; cs = 1'b1; as_n = 1'b0;
    @(negedge clk); as_n = 1'b1; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; cs = 1'b1; as_n = 1'b0;
    @(negedge clk); as_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); d = dout; rd_n = 1'b1;
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic hold_bit(input logic v, input int ticks);
    sin = v;
    repeat (ticks * div_cur) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit use_par,
                      input logic pbit, input logic s1, input bit use_s2, input logic s2);
    @(negedge clk);
    hold_bit(1'b0, 16);
    for (int i = 0; i < nb; i++) hold_bit(d[i], 16);
    if (use_par) hold_bit(pbit, 16);
    hold_bit(s1, 16);
    if (use_s2) hold_bit(s2, 16);
    hold_bit(1'b1, 48);
  endtask

  function automatic logic xor_n(input logic [7:0] d, input int nb);
    logic r = 1'b0;
    for (int i = 0; i < nb; i++) r ^= d[i];
    return r;
  endfunction

  task automatic flush();
    logic [7:0] t;
    rd(3'd5, t);
    rd(3'd0, t);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd5, v); chk("R1 lsr", v, 8'h60);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(3'd3, v); chk("R1 lcr", v, 8'h03);
    rd(3'd1, v); chk("R1 ier", v, 8'h00);
    wr(3'd3, 8'h83);
    rd(3'd0, v); chk("R1 div lo", v, 8'h01);
    rd(3'd1, v); chk("R1 div hi", v, 8'h00);
    wr(3'd3, 8'h03);
  endtask

  task automatic t_basic();
    logic [7:0] v;
    wr(3'd1, 8'h01); wr(3'd3, 8'h03);
    send(8'hA5, 8, 0, 0, 1, 0, 1);
    chk("R10 irq set", {7'b0, irq}, 8'h01);
    rd(3'd5, v); chk("R8 lsr first", v, 8'h61);
    rd(3'd5, v); chk("R8 lsr second", v, 8'h61);
    chk("R10 irq held", {7'b0, irq}, 8'h01);
    rd(3'd0, v); chk("R3 buffer 8N1", v, 8'hA5);
    chk("R10 irq dropped", {7'b0, irq}, 8'h00);
    rd(3'd5, v); chk("R9 ready cleared", v, 8'h60);
  endtask

  task automatic t_wlen();
    logic [7:0] v;
    wr(3'd3, 8'h19);
    send(8'h2A, 6, 1, xor_n(8'h2A, 6), 1, 0, 1);
    rd(3'd5, v); chk("R5 even ok", v, 8'h61);
    rd(3'd0, v); chk("R4 six bit", v, 8'h2A);
    wr(3'd3, 8'h01);
    send(8'h3F, 6, 0, 0, 1, 0, 1);
    rd(3'd0, v); chk("R4 six ones aligned", v, 8'h3F);
    wr(3'd3, 8'h0A);
    send(8'h56, 7, 1, ~xor_n(8'h56, 7), 1, 0, 1);
    rd(3'd5, v); chk("R5 odd ok", v, 8'h61);
    rd(3'd0, v); chk("R4 seven bit", v, 8'h56);
    wr(3'd3, 8'h00);
    send(8'h1F, 5, 0, 0, 1, 0, 1);
    rd(3'd0, v); chk("R4 five ones aligned", v, 8'h1F);
  endtask

  task automatic t_parity();
    logic [7:0] v;
    wr(3'd3, 8'h1B);
    send(8'h01, 8, 1, 1'b0, 1, 0, 1);
    rd(3'd5, v); chk("R5 even mismatch", v, 8'h65);
    rd(3'd5, v); chk("R8 pe cleared", v, 8'h61);
    rd(3'd0, v); chk("R5 data kept", v, 8'h01);
    wr(3'd3, 8'h0B);
    send(8'h03, 8, 1, 1'b0, 1, 0, 1);
    rd(3'd5, v); chk("R5 odd mismatch", v, 8'h65);
    flush();
  endtask

  task automatic t_stick();
    logic [7:0] v;
    wr(3'd3, 8'h2B);
    send(8'h01, 8, 1, 1'b1, 1, 0, 1);
    rd(3'd5, v); chk("R6 stick one ok", v, 8'h61);
    flush();
    send(8'h00, 8, 1, 1'b0, 1, 0, 1);
    rd(3'd5, v); chk("R6 stick one bad", v, 8'h65);
    flush();
    wr(3'd3, 8'h3B);
    send(8'h01, 8, 1, 1'b0, 1, 0, 1);
    rd(3'd5, v); chk("R6 stick zero ok", v, 8'h61);
    flush();
    send(8'h01, 8, 1, 1'b1, 1, 0, 1);
    rd(3'd5, v); chk("R6 stick zero bad", v, 8'h65);
    flush();
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    wr(3'd3, 8'h03);
    send(8'h11, 8, 0, 0, 1, 0, 1);
    send(8'h22, 8, 0, 0, 1, 0, 1);
    rd(3'd5, v); chk("R9 overrun", v, 8'h63);
    rd(3'd0, v); chk("R9 newest kept", v, 8'h22);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    wr(3'd3, 8'h03);
    send(8'h55, 8, 0, 0, 0, 0, 1);
    rd(3'd5, v); chk("R7 framing one stop", v, 8'h69);
    rd(3'd5, v); chk("R8 fe cleared", v, 8'h61);
    flush();
    wr(3'd3, 8'h07);
    send(8'h5A, 8, 0, 0, 1, 1, 0);
    rd(3'd5, v); chk("R7 second stop low", v, 8'h69);
    flush();
    send(8'h5A, 8, 0, 0, 1, 1, 1);
    rd(3'd5, v); chk("R7 two stops ok", v, 8'h61);
    flush();
    wr(3'd3, 8'h04);
    send(8'h15, 5, 0, 0, 1, 1, 0);
    rd(3'd5, v); chk("R7 half stop low", v, 8'h69);
    rd(3'd0, v); chk("R7 five bit data", v, 8'h15);
  endtask

  task automatic t_mask_break();
    logic [7:0] v;
    wr(3'd1, 8'hF0); wr(3'd3, 8'h43);
    rd(3'd1, v); chk("R2 ier upper masked", v, 8'h00);
    rd(3'd3, v); chk("R11 break readback", v, 8'h43);
    send(8'hC3, 8, 0, 0, 1, 0, 1);
    chk("R10 irq masked", {7'b0, irq}, 8'h00);
    rd(3'd5, v); chk("R11 rx with break", v, 8'h61);
    wr(3'd1, 8'h01);
    @(negedge clk);
    chk("R10 irq on enable", {7'b0, irq}, 8'h01);
    rd(3'd0, v); chk("R11 data with break", v, 8'hC3);
    chk("R10 irq off after read", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_divisor();
    logic [7:0] v;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h03); wr(3'd1, 8'h00);
    rd(3'd0, v); chk("R2 div lo", v, 8'h03);
    rd(3'd1, v); chk("R2 div hi", v, 8'h00);
    wr(3'd3, 8'h03);
    div_cur = 3;
    send(8'h3C, 8, 0, 0, 1, 0, 1);
    rd(3'd5, v); chk("R3 div3 ready", v, 8'h61);
    rd(3'd0, v); chk("R3 div3 data", v, 8'h3C);
    div_cur = 1;
    wr(3'd3, 8'h83); wr(3'd0, 8'h01); wr(3'd3, 8'h03);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs = 1'b0; as_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    addr = '0; din = '0; sin = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_wlen();
    t_parity();
    t_stick();
    t_overrun();
    t_stop();
    t_mask_break();
    t_divisor();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule